// File: doc/BRIEF.md
# Self-Refresh Entry Timing Configurator

This block prepares the settings a display source uses to drop a panel into self-refresh, and decides when to request entry. It takes raw panel parameters: an idle-frame count, two wake-time values (one for the first training pattern, one for the second/third), the source's high-bit-rate-2 support, the sink's third-training-pattern support, the source resolution and a capability flag for the deeper, selective-update mode. From these it builds a packed control word and a smaller word for the deeper mode. A wake-time value is sorted into one of four delay codes.

The words are captured on every clock while the enable input is low, and they hold still while it is high. With enable high, an idle counter advances on each frame-start strobe that comes without a screen update. It clears on any update strobe. When the counter first reaches the threshold, which is the configured idle count plus one, the block pulses an entry request for one cycle. It does not pulse again until an update re-arms it.

Top module: `sr_entry_cfg`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ctl_word`, `deep_word` and `entry_req` read zero.
- R2: On every clock edge where `en` is low, both words take the value computed from the current inputs. While `en` stays high, both words hold their value whatever the inputs do.
- R3: Bits [4:0] of `ctl_word` (the maximum sleep field) always read 0x1F once a capture has taken place.
- R4: Bits [9:5] of `ctl_word` hold the idle threshold, which equals `idle_frames` plus one (5 bits wide, so 15 gives 16).
- R5: Bits [11:10] of `ctl_word` code `tp1_wake`: a value above 5 gives 3 (2500 us), above 1 gives 2 (500 us), above 0 gives 1 (100 us), and 0 gives 0 (0 us).
- R6: Bits [13:12] of `ctl_word` code `tp23_wake` with the same thresholds and codes as R5.
- R7: Bit [14] of `ctl_word` is 1 (first/third pattern pair) only when both `hbr2_ok` and `sink_tps3` are 1. Otherwise it is 0 (first/second pattern pair).
- R8: Bits [3:2] of `deep_word` code `tp23_wake` with the R5 thresholds, where code 0 means 50 us. Bits [0] (deep-mode enable) and [1] (update tracking enable) are both 1 only when `deep_cap` is 1, `src_width` ≤ 3200 and `src_height` ≤ 2000. Otherwise both are 0.
- R9: With `en` high, a `frame_start` strobe without `frame_update` advances the idle count by one, up to the threshold. `frame_update` clears the count, and so does `en` being low.
- R10: `entry_req` is high for exactly one cycle, on the cycle after the `frame_start` that brings the count to the threshold. It does not rise again until a `frame_update` has cleared the count.
- R11: When `frame_start` and `frame_update` arrive in the same cycle, the update wins: the count clears and no request follows.
- R12: While `en` is low, `entry_req` stays low regardless of frame strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Arm: low = capture settings, high = freeze settings and count |
| idle_frames | input | 4 | Configured idle-frame count |
| tp1_wake | input | 4 | First training pattern wake-time value |
| tp23_wake | input | 4 | Second/third training pattern wake-time value |
| hbr2_ok | input | 1 | Source supports high bit rate 2 |
| sink_tps3 | input | 1 | Sink supports third training pattern |
| deep_cap | input | 1 | Panel supports the deeper selective-update mode |
| src_width | input | 12 | Source horizontal resolution |
| src_height | input | 12 | Source vertical resolution |
| frame_start | input | 1 | One-cycle strobe at each frame start |
| frame_update | input | 1 | One-cycle strobe when the screen content changed |
| ctl_word | output | 15 | Packed self-refresh control word |
| deep_word | output | 4 | Packed deeper-mode control word |
| entry_req | output | 1 | One-cycle self-refresh entry request |

## Verification
Two of the block's functions can act in the same cycle: advancing the idle count on a frame start, and clearing it on a screen update. The bench brings the count to one short of the threshold and then raises both strobes in the same cycle. It then requires that no request appears in the next cycle. It also requires that the threshold number of clean frame starts is needed again before a request appears, which shows that the count was cleared rather than held.

// File: rtl/sr_entry_pkg.sv
package sr_entry_pkg;

  typedef enum logic [1:0] {
    WAKE_MIN  = 2'd0,
    WAKE_100  = 2'd1,
    WAKE_500  = 2'd2,
    WAKE_2500 = 2'd3
  } wake_code_e;

  localparam int SLEEP_W = 5;
  localparam logic [SLEEP_W-1:0] SLEEP_MAX = 5'h1F;

  localparam int WAKE_HI  = 5;
  localparam int WAKE_MID = 1;
  localparam int WAKE_LO  = 0;

endpackage

// File: rtl/sr_wake_bucket.sv
module sr_wake_bucket
  import sr_entry_pkg::*;
#(
  parameter int WAKE_W = 4
) (
  input  logic [WAKE_W-1:0] wake_val,
  output wake_code_e        code
);

  always_comb begin
    if (wake_val > WAKE_W'(WAKE_HI))
      code = WAKE_2500;
    else if (wake_val > WAKE_W'(WAKE_MID))
      code = WAKE_500;
    else if (wake_val > WAKE_W'(WAKE_LO))
      code = WAKE_100;
    else
      code = WAKE_MIN;
  end

endmodule

// File: rtl/sr_cfg_pack.sv
module sr_cfg_pack
  import sr_entry_pkg::*;
#(
  parameter int IDLE_W = 4,
  parameter int WAKE_W = 4,
  parameter int DIM_W  = 12,
  parameter int MAX_W  = 3200,
  parameter int MAX_H  = 2000,
  localparam int THR_W  = IDLE_W + 1,
  localparam int CTL_W  = SLEEP_W + THR_W + 2 + 2 + 1,
  localparam int DEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [IDLE_W-1:0] idle_frames,
  input  logic [WAKE_W-1:0] tp1_wake,
  input  logic [WAKE_W-1:0] tp23_wake,
  input  logic              hbr2_ok,
  input  logic              sink_tps3,
  input  logic              deep_cap,
  input  logic [DIM_W-1:0]  src_width,
  input  logic [DIM_W-1:0]  src_height,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DEEP_W-1:0] deep_q,
  output logic [THR_W-1:0]  thr_q
);

  logic [WAKE_W-1:0] wake_in [2];
  wake_code_e        wake_cd [2];

  assign wake_in[0] = tp1_wake;
  assign wake_in[1] = tp23_wake;

  for (genvar g = 0; g < 2; g++) begin : g_bucket
    sr_wake_bucket #(.WAKE_W(WAKE_W)) u_bucket (
      .wake_val (wake_in[g]),
      .code     (wake_cd[g])
    );
  end

  logic [THR_W-1:0]  thr_next;
  logic              pat_sel;
  logic              dims_ok;
  logic              deep_on;
  logic [CTL_W-1:0]  ctl_next;
  logic [DEEP_W-1:0] deep_next;

  always_comb begin
    thr_next  = THR_W'(idle_frames) + THR_W'(1);
    pat_sel   = hbr2_ok & sink_tps3;
    dims_ok   = (32'(src_width) <= MAX_W) && (32'(src_height) <= MAX_H);
    deep_on   = deep_cap & dims_ok;
    ctl_next  = {pat_sel, wake_cd[1], wake_cd[0], thr_next, SLEEP_MAX};
    deep_next = {wake_cd[1], deep_on, deep_on};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      deep_q <= '0;
      thr_q  <= '0;
    end else if (!en) begin
      ctl_q  <= ctl_next;
      deep_q <= deep_next;
      thr_q  <= thr_next;
    end
  end

endmodule

// File: rtl/sr_idle_counter.sv
module sr_idle_counter #(
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic             frame_start,
  input  logic             frame_update,
  output logic             req
);

  logic [THR_W-1:0] cnt;
  logic             at_thr;
  logic             advance;
  logic             hit;

  always_comb begin
    at_thr  = (cnt == thr);
    advance = en && frame_start && !frame_update && !at_thr;
    hit     = advance && ((cnt + THR_W'(1)) == thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      req <= hit;
      if (!en || frame_update)
        cnt <= '0;
      else if (advance)
        cnt <= cnt + THR_W'(1);
    end
  end

endmodule

// File: rtl/sr_entry_cfg.sv
module sr_entry_cfg #(
  parameter int IDLE_W = 4,
  parameter int WAKE_W = 4,
  parameter int DIM_W  = 12,
  parameter int MAX_W  = 3200,
  parameter int MAX_H  = 2000,
  localparam int THR_W  = IDLE_W + 1,
  localparam int CTL_W  = 5 + THR_W + 2 + 2 + 1,
  localparam int DEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [IDLE_W-1:0] idle_frames,
  input  logic [WAKE_W-1:0] tp1_wake,
  input  logic [WAKE_W-1:0] tp23_wake,
  input  logic              hbr2_ok,
  input  logic              sink_tps3,
  input  logic              deep_cap,
  input  logic [DIM_W-1:0]  src_width,
  input  logic [DIM_W-1:0]  src_height,
  input  logic              frame_start,
  input  logic              frame_update,
  output logic [CTL_W-1:0]  ctl_word,
  output logic [DEEP_W-1:0] deep_word,
  output logic              entry_req
);

  logic [THR_W-1:0] thr;

  sr_cfg_pack #(
    .IDLE_W (IDLE_W),
    .WAKE_W (WAKE_W),
    .DIM_W  (DIM_W),
    .MAX_W  (MAX_W),
    .MAX_H  (MAX_H)
  ) u_pack (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .idle_frames (idle_frames),
    .tp1_wake    (tp1_wake),
    .tp23_wake   (tp23_wake),
    .hbr2_ok     (hbr2_ok),
    .sink_tps3   (sink_tps3),
    .deep_cap    (deep_cap),
    .src_width   (src_width),
    .src_height  (src_height),
    .ctl_q       (ctl_word),
    .deep_q      (deep_word),
    .thr_q       (thr)
  );

  sr_idle_counter #(.THR_W(THR_W)) u_idle (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .thr          (thr),
    .frame_start  (frame_start),
    .frame_update (frame_update),
    .req          (entry_req)
  );

endmodule

// File: rtl/sr_entry_cfg_chk.sv
module sr_entry_cfg_chk #(
  parameter int IDLE_W = 4,
  parameter int WAKE_W = 4,
  parameter int DIM_W  = 12,
  parameter int MAX_W  = 3200,
  parameter int MAX_H  = 2000,
  localparam int THR_W  = IDLE_W + 1,
  localparam int CTL_W  = 5 + THR_W + 2 + 2 + 1,
  localparam int DEEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [IDLE_W-1:0] idle_frames,
  input logic [WAKE_W-1:0] tp1_wake,
  input logic [WAKE_W-1:0] tp23_wake,
  input logic              hbr2_ok,
  input logic              sink_tps3,
  input logic              deep_cap,
  input logic [DIM_W-1:0]  src_width,
  input logic [DIM_W-1:0]  src_height,
  input logic              frame_start,
  input logic              frame_update,
  input logic [CTL_W-1:0]  ctl_word,
  input logic [DEEP_W-1:0] deep_word,
  input logic              entry_req
);

  p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    $past(en) && !$past(rst) |-> $stable(ctl_word) && $stable(deep_word));

  p_sleep_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(en) && !$past(rst) |-> ctl_word[4:0] == 5'h1F);

  p_deep_bound_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(en) && !$past(rst) &&
    ((32'($past(src_width)) > MAX_W) || (32'($past(src_height)) > MAX_H))
    |-> deep_word[1:0] == 2'b00);

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    entry_req |=> !entry_req);

  p_update_wins_r11: assert property (@(posedge clk) disable iff (rst)
    entry_req |-> !$past(frame_update) && $past(frame_start));

  p_needs_en_r12: assert property (@(posedge clk) disable iff (rst)
    entry_req |-> $past(en));

endmodule

bind sr_entry_cfg sr_entry_cfg_chk #(
  .IDLE_W (IDLE_W),
  .WAKE_W (WAKE_W),
  .DIM_W  (DIM_W),
  .MAX_W  (MAX_W),
  .MAX_H  (MAX_H)
) u_chk (.*);

// File: tb/sr_entry_cfg_tb.sv
module sr_entry_cfg_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [3:0]  idle_frames;
  logic [3:0]  tp1_wake;
  logic [3:0]  tp23_wake;
  logic        hbr2_ok;
  logic        sink_tps3;
  logic        deep_cap;
  logic [11:0] src_width;
  logic [11:0] src_height;
  logic        frame_start;
  logic        frame_update;
  logic [14:0] ctl_word;
  logic [3:0]  deep_word;
  logic        entry_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sr_entry_cfg u_dut (
    .clk, .rst, .en, .idle_frames, .tp1_wake, .tp23_wake, .hbr2_ok,
    .sink_tps3, .deep_cap, .src_width, .src_height, .frame_start,
    .frame_update, .ctl_word, .deep_word, .entry_req
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bucket(input int v);
    if (v > 5) return 3;
    if (v > 1) return 2;
    if (v > 0) return 1;
    return 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe(input bit fs, input bit fu);
    frame_start  = fs;
    frame_update = fu;
    tick();
    frame_start  = 1'b0;
    frame_update = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; idle_frames = 4'd3; tp1_wake = 4'd7; tp23_wake = 4'd2;
    hbr2_ok = 1'b1; sink_tps3 = 1'b1; deep_cap = 1'b1;
    src_width = 12'd1920; src_height = 12'd1080;
    frame_start = 1'b0; frame_update = 1'b0;
    tick(); tick();
    check(ctl_word == 0, "R1 ctl_word", ctl_word, 0);
    check(deep_word == 0, "R1 deep_word", deep_word, 0);
    check(entry_req == 0, "R1 entry_req", entry_req, 0);
    rst = 1'b0;
  endtask

  task automatic t_fields();
    for (int i = 0; i < 4; i++) begin
      idle_frames = 4'(i * 5);
      hbr2_ok     = i[0];
      sink_tps3   = i[1];
      tick();
      check(ctl_word[4:0] == 5'h1F, "R3 sleep field", ctl_word[4:0], 31);
      check(ctl_word[9:5] == 5'(i * 5 + 1), "R4 threshold", ctl_word[9:5], i * 5 + 1);
      check(ctl_word[14] == (i == 3), "R7 pattern select", ctl_word[14], i == 3);
    end
  endtask

  task automatic t_buckets();
    for (int v = 0; v < 10; v++) begin
      tp1_wake  = 4'(v);
      tp23_wake = 4'(9 - v);
      tick();
      check(ctl_word[11:10] == 2'(bucket(v)), "R5 tp1 code", ctl_word[11:10], bucket(v));
      check(ctl_word[13:12] == 2'(bucket(9 - v)), "R6 tp23 code", ctl_word[13:12], bucket(9 - v));
      check(deep_word[3:2] == 2'(bucket(9 - v)), "R8 deep tp2 code", deep_word[3:2], bucket(9 - v));
    end
  endtask

  task automatic t_deep();
    int ws [5] = '{3200, 3201, 3200, 640, 3200};
    int hs [5] = '{2000, 2000, 2001, 480, 2000};
    bit cs [5] = '{1, 1, 1, 1, 0};
    bit ex [5] = '{1, 0, 0, 1, 0};
    for (int k = 0; k < 5; k++) begin
      src_width = 12'(ws[k]); src_height = 12'(hs[k]); deep_cap = cs[k];
      tick();
      check(deep_word[1:0] == {ex[k], ex[k]}, "R8 deep enable", deep_word[1:0], ex[k] ? 3 : 0);
    end
  endtask

  task automatic t_freeze();
    logic [14:0] c0;
    logic [3:0]  d0;
    idle_frames = 4'd2; tp1_wake = 4'd0; tp23_wake = 4'd1;
    hbr2_ok = 1'b0; deep_cap = 1'b1; src_width = 12'd800; src_height = 12'd600;
    tick();
    c0 = ctl_word; d0 = deep_word;
    en = 1'b1;
    tick();
    idle_frames = 4'd9; tp1_wake = 4'd9; tp23_wake = 4'd9; hbr2_ok = 1'b1;
    sink_tps3 = 1'b1; deep_cap = 1'b0;
    tick(); tick();
    check(ctl_word == c0, "R2 ctl frozen", ctl_word, c0);
    check(deep_word == d0, "R2 deep frozen", deep_word, d0);
  endtask

  task automatic t_count();
    // threshold 3 (idle_frames 2 captured before en rose)
    strobe(1, 0);
    check(entry_req == 0, "R9 no req after 1", entry_req, 0);
    strobe(1, 0);
    check(entry_req == 0, "R9 no req after 2", entry_req, 0);
    strobe(1, 0);
    check(entry_req == 1, "R10 req at threshold", entry_req, 1);
    tick();
    check(entry_req == 0, "R10 single cycle", entry_req, 0);
    strobe(1, 0);
    check(entry_req == 0, "R10 no repeat", entry_req, 0);
    strobe(0, 1);
    strobe(1, 0); strobe(1, 0);
    check(entry_req == 0, "R9 cleared by update", entry_req, 0);
    strobe(1, 0);
    check(entry_req == 1, "R9 rearmed after update", entry_req, 1);
  endtask

  task automatic t_collide();
    strobe(0, 1);
    strobe(1, 0); strobe(1, 0);
    strobe(1, 1);
    check(entry_req == 0, "R11 update wins", entry_req, 0);
    strobe(1, 0); strobe(1, 0);
    check(entry_req == 0, "R11 count cleared", entry_req, 0);
    strobe(1, 0);
    check(entry_req == 1, "R11 full count needed", entry_req, 1);
  endtask

  task automatic t_en_low();
    bit seen = 1'b0;
    en = 1'b0;
    idle_frames = 4'd0;
    tick();
    for (int k = 0; k < 4; k++) begin
      strobe(1, 0);
      if (entry_req) seen = 1'b1;
    end
    check(!seen, "R12 no req while disabled", seen, 0);
    en = 1'b1;
    strobe(1, 0);
    check(entry_req == 1, "R9 threshold one fires", entry_req, 1);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_buckets();
    t_deep();
    t_freeze();
    t_count();
    t_collide();
    t_en_low();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule